// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath

This block is the register and arithmetic core of a small accumulator processor. Five storage elements can place their contents on one internal 8-bit bus: the accumulator, a result register, the program counter, the instruction register and the memory data register. Any register whose load strobe is high captures the bus on the next rising clock edge. The memory address register also loads from the bus. The memory data register takes its value only from external read data, when a valid strobe accompanies that data.

An adder/subtractor receives the bus as its B operand. Its A operand is either the accumulator or zero, picked by a pass control. The sum goes to the result register. With the A operand forced to zero, the result register can copy the bus operand or the bus operand plus one. This is how the program counter is incremented. The same path means no separate operand-holding register is needed. An external sequencer drives the thirteen control inputs every cycle. The block returns the opcode field of the instruction register and the current memory address.

Top module: `sdp_datapath`

## Requirements
- R1: After rst_ni is asserted, all six registers hold zero, so mem_addr_o and opcode_o read 0 and every register reads 0 when it is driven onto the bus.
- R2: The bus carries the value of the one source whose drive input is high. When no drive input is high, the bus is zero. At most one drive input may be high in a cycle.
- R3: On a rising edge, every register whose load input is high (accumulator, result, program counter, instruction, memory address) captures the bus. Every register whose load input is low keeps its value.
- R4: When the result register loads with pass_b_i=1, carry_i=0 and sub_i=0, it receives the bus value unchanged.
- R5: When the result register loads with pass_b_i=1, carry_i=1 and sub_i=0, it receives the bus value plus one, modulo 256.
- R6: When the result register loads with pass_b_i=0 and sub_i=0, it receives accumulator + bus + carry_i, modulo 256.
- R7: When the result register loads with sub_i=1, the B operand is inverted. The result is A + ~bus + carry_i, modulo 256, where A is the accumulator (pass_b_i=0) or zero (pass_b_i=1). With carry_i=1 and pass_b_i=0, this equals accumulator minus bus.
- R8: The memory data register loads mem_rd_data_i on a rising edge when mem_rd_valid_i is high. Otherwise it holds its value.
- R9: mem_addr_o always shows the memory address register. opcode_o always shows bits 7:6 of the instruction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_drive_i | input | 1 | Accumulator drives the bus |
| acc_load_i | input | 1 | Accumulator loads from the bus |
| res_drive_i | input | 1 | Result register drives the bus |
| res_load_i | input | 1 | Result register loads the adder output |
| pc_drive_i | input | 1 | Program counter drives the bus |
| pc_load_i | input | 1 | Program counter loads from the bus |
| ir_drive_i | input | 1 | Instruction register drives the bus |
| ir_load_i | input | 1 | Instruction register loads from the bus |
| mdr_drive_i | input | 1 | Memory data register drives the bus |
| mar_load_i | input | 1 | Memory address register loads from the bus |
| carry_i | input | 1 | Adder carry-in |
| sub_i | input | 1 | Invert the B operand (subtract) |
| pass_b_i | input | 1 | Force the A operand to zero |
| mem_rd_data_i | input | 8 | Memory read data |
| mem_rd_valid_i | input | 1 | Memory read data valid |
| opcode_o | output | 2 | Instruction register bits 7:6 |
| mem_addr_o | output | 8 | Memory address register |

## Verification
The bench builds the block with its default parameters: an 8-bit word and a 2-bit opcode. At this width, random operands reach the wrap of the increment at 0xFF and borrows in subtraction within a few thousand cycles. The bench cannot see internal registers directly. It checks each one by driving it onto the bus into the address register, and it compares mem_addr_o and opcode_o with its model after every cycle. Directed sequences cover the idle bus, the pass and increment settings, and subtraction with and without carry.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int unsigned NSRC = 5;
  typedef enum logic [2:0] {
    SRC_ACC = 3'd0,
    SRC_RES = 3'd1,
    SRC_PC  = 3'd2,
    SRC_IR  = 3'd3,
    SRC_MDR = 3'd4
  } src_e;
endpackage

// File: rtl/sdp_reg.sv
module sdp_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o)); // R3
  AST_REG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q_o == $past(d_i)); // R3
endmodule

// File: rtl/sdp_bus_mux.sv
module sdp_bus_mux
  import sdp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NSRC-1:0]         sel_i,
  input  logic [NSRC-1:0][W-1:0]  src_i,
  output logic [W-1:0]            bus_o
);
  logic [NSRC-1:0][W-1:0] term;

  // AND-OR bus: an idle bus resolves to zero
  for (genvar g = 0; g < NSRC; g++) begin : g_term
    assign term[g] = src_i[g] & {W{sel_i[g]}};
  end

  always_comb begin
    bus_o = '0;
    for (int i = 0; i < NSRC; i++) bus_o |= term[i];
  end

  AST_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i)); // R2
endmodule

// File: rtl/sdp_alu.sv
module sdp_alu #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         pass_b_i,
  input  logic         sub_i,
  input  logic         carry_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] a_op, b_op;

  always_comb begin
    a_op = pass_b_i ? '0 : a_i;
    b_op = sub_i ? ~b_i : b_i;
    y_o  = a_op + b_op + {{(W-1){1'b0}}, carry_i};
  end
endmodule

// File: rtl/sdp_datapath.sv
module sdp_datapath
  import sdp_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned OPW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           acc_drive_i,
  input  logic           acc_load_i,
  input  logic           res_drive_i,
  input  logic           res_load_i,
  input  logic           pc_drive_i,
  input  logic           pc_load_i,
  input  logic           ir_drive_i,
  input  logic           ir_load_i,
  input  logic           mdr_drive_i,
  input  logic           mar_load_i,
  input  logic           carry_i,
  input  logic           sub_i,
  input  logic           pass_b_i,
  input  logic [W-1:0]   mem_rd_data_i,
  input  logic           mem_rd_valid_i,
  output logic [OPW-1:0] opcode_o,
  output logic [W-1:0]   mem_addr_o
);
  logic [W-1:0] bus, alu_y, acc_q, res_q, pc_q, ir_q, mdr_q, mar_q;
  logic [NSRC-1:0] drv;
  logic [NSRC-1:0][W-1:0] srcs;

  always_comb begin
    drv[SRC_ACC] = acc_drive_i;
    drv[SRC_RES] = res_drive_i;
    drv[SRC_PC]  = pc_drive_i;
    drv[SRC_IR]  = ir_drive_i;
    drv[SRC_MDR] = mdr_drive_i;
    srcs[SRC_ACC] = acc_q;
    srcs[SRC_RES] = res_q;
    srcs[SRC_PC]  = pc_q;
    srcs[SRC_IR]  = ir_q;
    srcs[SRC_MDR] = mdr_q;
  end

  sdp_bus_mux #(.W(W)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(drv), .src_i(srcs), .bus_o(bus)
  );

  sdp_alu #(.W(W)) u_alu (
    .a_i(acc_q), .b_i(bus), .pass_b_i(pass_b_i), .sub_i(sub_i),
    .carry_i(carry_i), .y_o(alu_y)
  );

  sdp_reg #(.W(W)) u_acc (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(acc_load_i), .d_i(bus),   .q_o(acc_q));
  sdp_reg #(.W(W)) u_res (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(res_load_i), .d_i(alu_y), .q_o(res_q));
  sdp_reg #(.W(W)) u_pc  (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(pc_load_i),  .d_i(bus),   .q_o(pc_q));
  sdp_reg #(.W(W)) u_ir  (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ir_load_i),  .d_i(bus),   .q_o(ir_q));
  sdp_reg #(.W(W)) u_mar (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(mar_load_i), .d_i(bus),   .q_o(mar_q));
  sdp_reg #(.W(W)) u_mdr (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(mem_rd_valid_i),
                          .d_i(mem_rd_data_i), .q_o(mdr_q));

  assign opcode_o   = ir_q[W-1 -: OPW];
  assign mem_addr_o = mar_q;

  AST_PASS_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_load_i && pass_b_i && !carry_i && !sub_i) |=> res_q == $past(bus)); // R4
  AST_MAR_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mar_load_i |=> mem_addr_o == $past(bus)); // R9
  AST_OPCODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_load_i |=> $stable(opcode_o)); // R9
  AST_MDR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_i |=> mdr_q == $past(mem_rd_data_i)); // R8
endmodule

// File: tb/sim_sdp_datapath.sv
module sim_sdp_datapath;
  localparam int  W = 8;
  localparam int  OPW = 2;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] drv, ld;
  logic cin, sub, pass, valid;
  logic [W-1:0] md;
  logic [OPW-1:0] opcode;
  logic [W-1:0] maddr;

  // source order: acc, res, pc, ir, mdr; load order: acc, res, pc, ir, mar
  logic [W-1:0] m_acc, m_res, m_pc, m_ir, m_mdr, m_mar;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdp_datapath #(.W(W), .OPW(OPW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_drive_i(drv[0]), .acc_load_i(ld[0]),
    .res_drive_i(drv[1]), .res_load_i(ld[1]),
    .pc_drive_i(drv[2]),  .pc_load_i(ld[2]),
    .ir_drive_i(drv[3]),  .ir_load_i(ld[3]),
    .mdr_drive_i(drv[4]), .mar_load_i(ld[4]),
    .carry_i(cin), .sub_i(sub), .pass_b_i(pass),
    .mem_rd_data_i(md), .mem_rd_valid_i(valid),
    .opcode_o(opcode), .mem_addr_o(maddr)
  );

  function automatic logic [W-1:0] exp_alu(logic [W-1:0] a, logic [W-1:0] b,
                                           logic p, logic s, logic c);
    logic [W-1:0] aa, bb;
    aa = p ? '0 : a;
    bb = s ? ~b : b;
    return aa + bb + W'(c);
  endfunction

  task automatic check(string tag);
    checks++;
    if (maddr !== m_mar || opcode !== m_ir[W-1 -: OPW]) begin
      fails++;
      $display("FAIL %s: addr=%h op=%0d expected addr=%h op=%0d",
               tag, maddr, opcode, m_mar, m_ir[W-1 -: OPW]);
    end
  endtask

  // called at a falling edge; applies controls, then checks at the next falling edge
  task automatic cyc(logic [4:0] d, logic [4:0] l, logic c, logic s, logic p,
                     logic v, logic [W-1:0] data, string tag);
    logic [W-1:0] b;
    drv = d; ld = l; cin = c; sub = s; pass = p; valid = v; md = data;
    b = '0;
    if (d[0]) b = m_acc;
    if (d[1]) b = m_res;
    if (d[2]) b = m_pc;
    if (d[3]) b = m_ir;
    if (d[4]) b = m_mdr;
    if (l[1]) m_res = exp_alu(m_acc, b, p, s, c);
    if (l[0]) m_acc = b;
    if (l[2]) m_pc  = b;
    if (l[3]) m_ir  = b;
    if (l[4]) m_mar = b;
    if (v)    m_mdr = data;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    drv = '0; ld = '0; cin = 0; sub = 0; pass = 0; valid = 0; md = '0;
    m_acc = '0; m_res = '0; m_pc = '0; m_ir = '0; m_mdr = '0; m_mar = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs");
    for (int i = 0; i < 5; i++) cyc(5'(1 << i), 5'b10000, 0, 0, 0, 0, '0, "R1 reset register");

    // R8: memory data loads only with valid
    cyc(5'b00000, 5'b00000, 0, 0, 0, 1, 8'hC5, "R8 load");
    cyc(5'b00000, 5'b00000, 0, 0, 0, 0, 8'h11, "R8 hold");
    cyc(5'b10000, 5'b11001, 0, 0, 0, 0, '0, "R8 R3 fanout");
    // R2: idle bus is zero
    cyc(5'b00000, 5'b10000, 0, 0, 0, 0, '0, "R2 idle bus");
    cyc(5'b00001, 5'b10000, 0, 0, 0, 0, '0, "R3 acc");
    // R4: pass-through
    cyc(5'b01000, 5'b00010, 0, 0, 1, 0, '0, "R4 pass");
    cyc(5'b00010, 5'b10000, 0, 0, 0, 0, '0, "R4 readout");
    // R5: increment with wrap
    cyc(5'b00000, 5'b00000, 0, 0, 0, 1, 8'hFF, "R5 setup");
    cyc(5'b10000, 5'b00100, 0, 0, 0, 0, '0, "R5 pc load");
    cyc(5'b00100, 5'b00010, 1, 0, 1, 0, '0, "R5 inc");
    cyc(5'b00010, 5'b10100, 0, 0, 0, 0, '0, "R5 wrap readout");
    // R6 / R7: add and subtract
    cyc(5'b00000, 5'b00000, 0, 0, 0, 1, 8'h03, "R6 setup");
    cyc(5'b10000, 5'b00010, 1, 0, 0, 0, '0, "R6 add");
    cyc(5'b00010, 5'b10000, 0, 0, 0, 0, '0, "R6 readout");
    cyc(5'b10000, 5'b00010, 1, 1, 0, 0, '0, "R7 sub");
    cyc(5'b00010, 5'b10000, 0, 0, 0, 0, '0, "R7 readout");
    cyc(5'b10000, 5'b00010, 0, 1, 1, 0, '0, "R7 invert");
    cyc(5'b00010, 5'b10000, 0, 0, 0, 0, '0, "R7 invert readout");

    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [4:0] d;
      r = $urandom % 6;
      d = (r < 5) ? 5'(1 << r) : 5'b0;
      cyc(d, 5'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), W'($urandom), "R3 R9 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule